// File: doc/BRIEF.md
# Dual H-Bridge Gate Decoder with Break-Before-Make Timing

This block sits between the control logic of a two-bridge motor driver and its gate drivers. For each bridge it reads two direction inputs and produces gate enables for the four switches of that bridge. Each bridge has two legs, one for each output, and each leg has a high-side switch and a low-side switch. The four input combinations select coast, forward, reverse or brake. Coast turns every switch off. Brake turns on both low sides.

Each leg has its own counter. When the leg has to go from one switch to the opposite one, the counter holds both switches off for a programmable number of clock cycles before the new switch turns on. A leg whose switch does not change keeps it on with no gap.

Three conditions force gates off on the next clock edge, with no waiting:
- a global active-low sleep input turns off both bridges;
- a per-bridge fault disable turns off only its own bridge;
- a per-bridge chopping request acts only on a bridge that is driving forward or reverse. It turns that bridge's high side off and moves the bridge to brake, so the winding current decays slowly through the low sides.

Top module: `hbridge_gate_ctrl`

## Requirements
- R1: With both direction inputs of a bridge low, all four gate enables of that bridge are 0 (coast).
- R2: With in1=1 and in2=0 a bridge drives forward: the high side of leg OUT1 and the low side of leg OUT2 are on, and the other two switches are off.
- R3: With in1=0 and in2=1 a bridge drives reverse: the low side of leg OUT1 and the high side of leg OUT2 are on, and the other two switches are off.
- R4: With both direction inputs high, both low sides of the bridge are on and both high sides are off (brake).
- R5: The high-side and low-side enables of the same leg are never 1 in the same cycle.
- R6: Once a leg's switch turns off, neither switch of that leg turns on again until the leg has been fully off for DEAD_CYCLES cycles. The replacement switch turns on in exactly the DEAD_CYCLES+1-th cycle after the first cycle in which the new request is presented.
- R7: A leg whose requested switch stays the same across a state change keeps that switch on in every cycle, with no gap.
- R8: While sleep_n is low, all gate enables are 0 from the next cycle on, and the direction inputs have no effect.
- R9: fault_off[b] forces all four enables of bridge b to 0 in the next cycle and leaves the other bridge unaffected.
- R10: chop_req[b] turns a forward or reverse bridge b into brake, with its high sides off from the next cycle. It has no effect on a bridge in coast or brake.
- R11: During reset all enables are 0. A drive request present when reset is released is applied one cycle later, without a dead-time wait.
- R12: If a disable turned a switch off, then after the disable ends the leg still waits out the dead time, counted from the turn-off, before turning a switch on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_n | input | 1 | Active-low sleep; low forces every gate off |
| in1 | input | NUM_BRIDGES | Direction input 1 per bridge |
| in2 | input | NUM_BRIDGES | Direction input 2 per bridge |
| chop_req | input | NUM_BRIDGES | Chopping override per bridge; drive becomes brake |
| fault_off | input | NUM_BRIDGES | Per-bridge fault disable |
| hs_en | output | 2*NUM_BRIDGES | High-side enables; bit 2b is leg OUT1 and bit 2b+1 is leg OUT2 of bridge b |
| ls_en | output | 2*NUM_BRIDGES | Low-side enables, with the same leg order as hs_en |

## Verification
The bench builds the block with two bridges and DEAD_CYCLES set to 5 instead of the default 75. With that value a reversal settles within a few cycles, so the bench can sample every cycle of a break-before-make window and catch an off-by-one at either end of it. Two bridges are enough to show that fault disable and chopping act on one bridge while the other keeps driving.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  // Request for one leg of a bridge
  typedef enum logic [1:0] {
    LEG_OFF  = 2'd0,
    LEG_HIGH = 2'd1,
    LEG_LOW  = 2'd2
  } leg_req_e;

  typedef struct packed {
    leg_req_e out1;
    leg_req_e out2;
  } bridge_req_t;

  // Direction inputs plus chopping override -> per-leg request
  function automatic bridge_req_t decode_bridge(logic a, logic b, logic chop);
    bridge_req_t r;
    unique case ({a, b})
      2'b00:   begin r.out1 = LEG_OFF;  r.out2 = LEG_OFF;  end
      2'b10:   begin r.out1 = LEG_HIGH; r.out2 = LEG_LOW;  end
      2'b01:   begin r.out1 = LEG_LOW;  r.out2 = LEG_HIGH; end
      default: begin r.out1 = LEG_LOW;  r.out2 = LEG_LOW;  end
    endcase
    // chopping only acts on a driving bridge; it becomes brake
    if (chop && (a ^ b)) begin
      r.out1 = LEG_LOW;
      r.out2 = LEG_LOW;
    end
    return r;
  endfunction

  // Width of a down-counter that must hold n-1
  function automatic int gap_width(int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/hbg_bridge_decode.sv
module hbg_bridge_decode
  import hbg_pkg::*;
(
  input  logic     in1,
  input  logic     in2,
  input  logic     chop,
  input  logic     sleep_n,
  input  logic     fault_off,
  output leg_req_e req_out1,
  output leg_req_e req_out2,
  output logic     kill
);

  bridge_req_t dec;

  always_comb begin
    dec      = decode_bridge(in1, in2, chop);
    req_out1 = dec.out1;
    req_out2 = dec.out2;
    kill     = !sleep_n || fault_off;
  end

endmodule

// File: rtl/hbg_leg_timer.sv
module hbg_leg_timer
  import hbg_pkg::*;
#(
  parameter int DEAD_CYCLES = 75
)(
  input  logic     clk,
  input  logic     rst_n,
  input  leg_req_e req,
  input  logic     kill,
  output logic     hs_en,
  output logic     ls_en
);

  localparam int CW = gap_width(DEAD_CYCLES);
  localparam logic [CW-1:0] RELOAD = CW'(DEAD_CYCLES - 1);

  leg_req_e      state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;

  // named events
  logic leg_on, want_off, turn_off_evt, turn_on_evt, gap_done;

  always_comb begin
    leg_on       = (state_q != LEG_OFF);
    want_off     = kill || (req == LEG_OFF);
    gap_done     = (cnt_q == '0);
    turn_off_evt = leg_on && (want_off || (req != state_q));
    turn_on_evt  = !leg_on && !want_off && gap_done;

    state_n = state_q;
    if (turn_off_evt)     state_n = LEG_OFF;
    else if (turn_on_evt) state_n = req;

    cnt_n = cnt_q;
    if (turn_off_evt)   cnt_n = RELOAD;
    else if (!gap_done) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LEG_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
    end
  end

  assign hs_en = (state_q == LEG_HIGH);
  assign ls_en = (state_q == LEG_LOW);

endmodule

// File: rtl/hbridge_gate_ctrl.sv
module hbridge_gate_ctrl
  import hbg_pkg::*;
#(
  parameter int NUM_BRIDGES = 2,
  parameter int DEAD_CYCLES = 75   // 300 ns at 250 MHz; must be >= 1
)(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sleep_n,
  input  logic [NUM_BRIDGES-1:0]   in1,
  input  logic [NUM_BRIDGES-1:0]   in2,
  input  logic [NUM_BRIDGES-1:0]   chop_req,
  input  logic [NUM_BRIDGES-1:0]   fault_off,
  output logic [2*NUM_BRIDGES-1:0] hs_en,
  output logic [2*NUM_BRIDGES-1:0] ls_en
);

  localparam int NUM_LEGS = 2 * NUM_BRIDGES;

  leg_req_e             leg_req [NUM_LEGS];
  logic [NUM_BRIDGES-1:0] bridge_kill;

  for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_bridge
    hbg_bridge_decode u_dec (
      .in1       (in1[b]),
      .in2       (in2[b]),
      .chop      (chop_req[b]),
      .sleep_n   (sleep_n),
      .fault_off (fault_off[b]),
      .req_out1  (leg_req[2*b]),
      .req_out2  (leg_req[2*b+1]),
      .kill      (bridge_kill[b])
    );

    for (genvar s = 0; s < 2; s++) begin : g_leg
      hbg_leg_timer #(.DEAD_CYCLES(DEAD_CYCLES)) u_leg (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (leg_req[2*b+s]),
        .kill  (bridge_kill[b]),
        .hs_en (hs_en[2*b+s]),
        .ls_en (ls_en[2*b+s])
      );
    end
  end

endmodule

// File: rtl/hbg_checker.sv
module hbg_checker #(
  parameter int NUM_BRIDGES = 2,
  parameter int DEAD_CYCLES = 75
)(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     sleep_n,
  input logic [NUM_BRIDGES-1:0]   in1,
  input logic [NUM_BRIDGES-1:0]   in2,
  input logic [NUM_BRIDGES-1:0]   chop_req,
  input logic [NUM_BRIDGES-1:0]   fault_off,
  input logic [2*NUM_BRIDGES-1:0] hs_en,
  input logic [2*NUM_BRIDGES-1:0] ls_en
);

  localparam int NL = 2 * NUM_BRIDGES;
  localparam int GW = $clog2(DEAD_CYCLES + 2);
  localparam logic [GW-1:0] GMAX = GW'(DEAD_CYCLES + 1);
  localparam logic [GW-1:0] GMIN = GW'(DEAD_CYCLES);

  AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_n |=> (hs_en == '0 && ls_en == '0));  // R8

  for (genvar l = 0; l < NL; l++) begin : g_leg
    logic [GW-1:0] gap_q;
    logic          seen_q, prev_hs_q;
    logic          any_on;
    assign any_on = hs_en[l] || ls_en[l];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gap_q     <= '0;
        seen_q    <= 1'b0;
        prev_hs_q <= 1'b0;
      end else if (any_on) begin
        gap_q     <= '0;
        seen_q    <= 1'b1;
        prev_hs_q <= hs_en[l];
      end else if (gap_q != GMAX) begin
        gap_q <= gap_q + 1'b1;
      end
    end

    AST_LEG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_en[l] && ls_en[l]));  // R5

    AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && any_on && gap_q != '0) |-> (gap_q >= GMIN));  // R6

    AST_NO_DIRECT_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_q && any_on && gap_q == '0) |-> (hs_en[l] == prev_hs_q));  // R6
  end

  for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_br
    AST_FAULT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      fault_off[b] |=> (hs_en[2*b+1 -: 2] == 2'b00 && ls_en[2*b+1 -: 2] == 2'b00));  // R9

    AST_CHOP_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (chop_req[b] && (in1[b] ^ in2[b])) |=> (hs_en[2*b+1 -: 2] == 2'b00));  // R10
  end

endmodule

bind hbridge_gate_ctrl hbg_checker #(
  .NUM_BRIDGES (NUM_BRIDGES),
  .DEAD_CYCLES (DEAD_CYCLES)
) u_hbg_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .sleep_n   (sleep_n),
  .in1       (in1),
  .in2       (in2),
  .chop_req  (chop_req),
  .fault_off (fault_off),
  .hs_en     (hs_en),
  .ls_en     (ls_en)
);

// File: tb/hbridge_gate_ctrl_bench.sv
module hbridge_gate_ctrl_bench;

  localparam int NB   = 2;
  localparam int DEAD = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sleep_n = 1'b1;
  logic [NB-1:0] in1 = '0, in2 = '0, chop_req = '0, fault_off = '0;
  logic [3:0]    hs_en, ls_en;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  hbridge_gate_ctrl #(.NUM_BRIDGES(NB), .DEAD_CYCLES(DEAD)) u_hbridge_gate_ctrl (
    .clk, .rst_n, .sleep_n, .in1, .in2, .chop_req, .fault_off, .hs_en, .ls_en
  );

  // Leg bit order: {b1.out2, b1.out1, b0.out2, b0.out1}
  typedef struct packed {
    logic [3:0] req;
    logic       slp_n;
    logic [1:0] i1, i2, ch, ft;
    logic [3:0] hs, ls;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{4'd1,  1'b1, 2'b00, 2'b00, 2'b00, 2'b00, 4'b0000, 4'b0000},  // R1 coast
    '{4'd2,  1'b1, 2'b01, 2'b00, 2'b00, 2'b00, 4'b0001, 4'b0010},  // R2 b0 forward
    '{4'd3,  1'b1, 2'b00, 2'b01, 2'b00, 2'b00, 4'b0010, 4'b0001},  // R3 b0 reverse
    '{4'd4,  1'b1, 2'b01, 2'b01, 2'b00, 2'b00, 4'b0000, 4'b0011},  // R4 b0 brake
    '{4'd3,  1'b1, 2'b10, 2'b01, 2'b00, 2'b00, 4'b0110, 4'b1001},  // R3 b0 rev, b1 fwd
    '{4'd4,  1'b1, 2'b11, 2'b11, 2'b00, 2'b00, 4'b0000, 4'b1111},  // R4 both brake
    '{4'd2,  1'b1, 2'b01, 2'b10, 2'b00, 2'b00, 4'b1001, 4'b0110},  // R2 b0 fwd, b1 rev
    '{4'd10, 1'b1, 2'b01, 2'b10, 2'b01, 2'b00, 4'b1000, 4'b0111},  // R10 chop b0 only
    '{4'd10, 1'b1, 2'b01, 2'b10, 2'b11, 2'b00, 4'b0000, 4'b1111},  // R10 chop both
    '{4'd10, 1'b1, 2'b00, 2'b00, 2'b11, 2'b00, 4'b0000, 4'b0000},  // R10 chop in coast
    '{4'd9,  1'b1, 2'b01, 2'b10, 2'b00, 2'b10, 4'b0001, 4'b0010},  // R9 fault b1 only
    '{4'd8,  1'b0, 2'b01, 2'b10, 2'b00, 2'b00, 4'b0000, 4'b0000}   // R8 sleep
  };

  task automatic check(string tag, logic [3:0] ah, logic [3:0] al,
                       logic [3:0] eh, logic [3:0] el);
    n_tests++;
    if (ah !== eh || al !== el) begin
      n_fail++;
      $display("FAIL %s: hs=%b ls=%b expected hs=%b ls=%b", tag, ah, al, eh, el);
    end
  endtask

  task automatic drive(logic s, logic [1:0] a, logic [1:0] b,
                       logic [1:0] c, logic [1:0] f);
    sleep_n = s; in1 = a; in2 = b; chop_req = c; fault_off = f;
  endtask

  initial begin
    #(200000 * 4);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R11: reset holds all off even with forward requested
    drive(1'b1, 2'b01, 2'b00, 2'b00, 2'b00);
    repeat (3) @(negedge clk);
    check("R11 reset off", hs_en, ls_en, 4'b0000, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 first drive after reset", hs_en, ls_en, 4'b0001, 4'b0010);

    // Vector table walk
    for (int i = 0; i < 12; i++) begin
      drive(VECS[i].slp_n, VECS[i].i1, VECS[i].i2, VECS[i].ch, VECS[i].ft);
      repeat (DEAD + 3) @(negedge clk);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), hs_en, ls_en, VECS[i].hs, VECS[i].ls);
    end

    // R6: exact break-before-make window on a b0 reversal
    drive(1'b1, 2'b01, 2'b00, 2'b00, 2'b00);
    repeat (DEAD + 3) @(negedge clk);
    drive(1'b1, 2'b00, 2'b01, 2'b00, 2'b00);
    for (int j = 0; j < DEAD; j++) begin
      @(negedge clk);
      check("R6 dead window", hs_en, ls_en, 4'b0000, 4'b0000);
    end
    @(negedge clk);
    check("R6 turn-on after dead time", hs_en, ls_en, 4'b0010, 4'b0001);

    // R7: forward -> chop brake, OUT2 low side stays on every cycle
    drive(1'b1, 2'b01, 2'b00, 2'b00, 2'b00);
    repeat (DEAD + 3) @(negedge clk);
    drive(1'b1, 2'b01, 2'b00, 2'b01, 2'b00);
    for (int j = 0; j < DEAD; j++) begin
      @(negedge clk);
      check("R7 unchanged leg held", hs_en, ls_en, 4'b0000, 4'b0010);
    end
    @(negedge clk);
    check("R7 brake reached", hs_en, ls_en, 4'b0000, 4'b0011);

    // R12 / R9: one-cycle fault on b0 while b1 drives forward
    drive(1'b1, 2'b11, 2'b00, 2'b00, 2'b00);
    repeat (DEAD + 3) @(negedge clk);
    check("R2 both forward", hs_en, ls_en, 4'b0101, 4'b1010);
    drive(1'b1, 2'b11, 2'b00, 2'b00, 2'b01);
    @(negedge clk);
    check("R9 fault b0 only", hs_en, ls_en, 4'b0100, 4'b1000);
    drive(1'b1, 2'b11, 2'b00, 2'b00, 2'b00);
    for (int j = 1; j < DEAD; j++) begin
      @(negedge clk);
      check("R12 wait after fault", hs_en, ls_en, 4'b0100, 4'b1000);
    end
    @(negedge clk);
    check("R12 resume after fault", hs_en, ls_en, 4'b0101, 4'b1010);

    // R8: sleep is immediate and ignores inputs
    drive(1'b0, 2'b11, 2'b00, 2'b00, 2'b00);
    @(negedge clk);
    check("R8 sleep immediate", hs_en, ls_en, 4'b0000, 4'b0000);
    for (int j = 0; j < 4; j++) begin
      drive(1'b0, 2'(j), 2'(3 - j), 2'b00, 2'b00);
      @(negedge clk);
      check("R8 inputs ignored", hs_en, ls_en, 4'b0000, 4'b0000);
    end
    drive(1'b0, 2'b11, 2'b00, 2'b00, 2'b00);
    repeat (DEAD + 2) @(negedge clk);
    drive(1'b1, 2'b11, 2'b00, 2'b00, 2'b00);
    @(negedge clk);
    check("R8 wake after long sleep", hs_en, ls_en, 4'b0101, 4'b1010);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule